// File: doc/BRIEF.md
# OTP Protection Register Controller

The block models a one-time-programmable protection area for a word-wide memory slave. The area holds a first 128-bit register, split into a lower and an upper 64-bit half, and sixteen further 128-bit user registers. Two lock words sit beside the data. Every write cycle arrives on a valid/ready write channel as a 16-bit word at a 9-bit word address. Reads use a valid/ready request channel and a valid/ready response channel.

Programming takes two write cycles. The first cycle carries a program command at the target address, and the next write carries the data. A program can only clear bits. It is refused when the address lies outside the area, and also when the target register is locked. A refusal raises sticky error flags in a status word. The host reads that status word after switching the read path into status mode. Lock bits follow the same clear-only rule, so a lock can never be removed. The lower half of the first register is locked from reset.

The write channel never stalls: `wr_ready` is tied high. The read request channel applies back-pressure through `rd_ready`. It accepts a request when no response is pending, or when the pending response is taken in the same cycle. A response appears one cycle after its request is accepted. It holds its value until `rdata_ready` is seen high.

Top module: `otp_prot_ctrl`

## Requirements
- R1: In the idle state, a write whose low byte is 0xC0 arms a program at that write's address. The next write, whatever its address, supplies the data, and the target is the address latched with the command.
- R2: A permitted program stores the AND of the old word and the data word, so programming can only turn ones into zeros.
- R3: The word map is fixed.
  - 0x80 holds lock word 0, and 0x89 holds lock word 1.
  - 0x81 to 0x84 hold the lower half of the first register, and 0x85 to 0x88 hold its upper half.
  - User register n (1 to 16) occupies 0x8A+8*(n-1) to 0x8A+8*(n-1)+7.
  - In array mode, a read returns the stored word, and a read of any other address returns 0xFFFF.
- R4: A program aimed at an address outside 0x80 to 0x109 sets status bit 4 and changes no stored word.
- R5: A program aimed at a locked data word sets status bits 4 and 1 together and changes no stored word.
- R6: A program at 0x80 or 0x89 ANDs the data into that lock word. No command can set a lock bit from zero back to one.
- R7: After reset, every data word reads 0xFFFF, lock word 0 reads 0xFFFE, lock word 1 reads 0xFFFF, and the status word reads 0x0080. Bit 0 of lock word 0 is zero at all times.
- R8: A zero in bit 1 of lock word 0 locks the upper half of the first register. A zero in bit 0 of lock word 0 locks its lower half. A zero in bit k of lock word 1 locks user register k+1.
- R9: The commands act as follows.
  - Command 0x70 switches reads to status mode. Every read then returns bit 7 = 1 (ready), bit 4 = program error and bit 1 = lock error, with all other bits zero.
  - Command 0xFF returns reads to array mode.
  - Command 0x50 clears both error bits.
  - The error bits otherwise stay set.
- R10: The read channel behaves as follows.
  - `rd_ready` equals `!rdata_valid || rdata_ready`.
  - An accepted request yields `rdata_valid` on the next cycle.
  - While `rdata_valid` is high and `rdata_ready` is low, `rdata` and `rdata_valid` hold.
- R11: The write channel never stalls: `wr_ready` is always high. In the idle state, a write whose low byte is not 0xC0, 0x70, 0x50 or 0xFF changes neither the stored data nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write cycle present |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 9 | Word address of the write cycle |
| wr_data | input | 16 | Command code (low byte) or program data |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | 9 | Word address to read |
| rdata_valid | output | 1 | Read response present |
| rdata_ready | input | 1 | Consumer takes the response |
| rdata | output | 16 | Stored word, lock word or status word |

## Verification
The bench works through the addressing and locking corner cases.

- It programs the first and last word of every register, so a decoder that is off by one at the half boundary, or at the user-register stride, would corrupt a neighbouring word. It would also raise a false lock error.
- It programs outside the area and into locked words. A design that wrote through anyway would show a changed word. A design that mixed up the two flags would report the wrong status word.
- It writes all ones to lock words that were already cleared. This catches a plain store in place of an AND merge.
- It programs with the data cycle at a different address. This catches a design that takes the second cycle's address as the target.
- It holds the response channel under back-pressure. A design that overwrote or dropped a stalled response would then fail its scoreboard comparison.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] CMD_PROGRAM   = 8'hC0;
  localparam logic [7:0] CMD_READ_STAT = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_READ_ARR  = 8'hFF;

  localparam int LOCK0_WORD = 'h80;

  localparam int ST_READY_BIT = 7;
  localparam int ST_PERR_BIT  = 4;
  localparam int ST_LERR_BIT  = 1;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_LOCK0 = 2'd1,
    RGN_LOCK1 = 2'd2,
    RGN_DATA  = 2'd3
  } region_e;
endpackage

// File: rtl/otp_addr_map.sv
module otp_addr_map
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int USER_REGS = 16,
  parameter int REG_WORDS = 8,
  localparam int WORDS    = REG_WORDS * (USER_REGS + 1),
  localparam int IDX_W    = $clog2(WORDS),
  localparam int RSEL_W   = $clog2(USER_REGS)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    lock0,
  input  logic [USER_REGS-1:0] lock1,
  output region_e              region,
  output logic [IDX_W-1:0]     idx,
  output logic                 locked
);
  localparam int LOG_RW = $clog2(REG_WORDS);
  localparam logic [ADDR_W-1:0] LOCK0_A = ADDR_W'(LOCK0_WORD);
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(LOCK0_WORD + 1);
  localparam logic [ADDR_W-1:0] LOCK1_A = ADDR_W'(LOCK0_WORD + 1 + REG_WORDS);
  localparam logic [ADDR_W-1:0] USER_A  = ADDR_W'(LOCK0_WORD + 2 + REG_WORDS);
  localparam logic [ADDR_W-1:0] LAST_A  =
    ADDR_W'(LOCK0_WORD + 1 + REG_WORDS + USER_REGS * REG_WORDS);
  localparam logic [IDX_W-1:0]  HALF_I  = IDX_W'(REG_WORDS / 2);
  localparam logic [IDX_W-1:0]  RW_I    = IDX_W'(REG_WORDS);

  logic [ADDR_W-1:0] off_first;
  logic [ADDR_W-1:0] off_user;
  logic [RSEL_W-1:0] reg_sel;

  assign off_first = addr - FIRST_A;
  assign off_user  = addr - USER_A;
  assign reg_sel   = RSEL_W'(off_user >> LOG_RW);

  always_comb begin
    region = RGN_NONE;
    idx    = '0;
    locked = 1'b0;
    if (addr == LOCK0_A) begin
      region = RGN_LOCK0;
    end else if (addr == LOCK1_A) begin
      region = RGN_LOCK1;
    end else if (addr >= FIRST_A && addr < LOCK1_A) begin
      region = RGN_DATA;
      idx    = IDX_W'(off_first);
      locked = (IDX_W'(off_first) < HALF_I) ? ~lock0[0] : ~lock0[1];
    end else if (addr >= USER_A && addr <= LAST_A) begin
      region = RGN_DATA;
      idx    = IDX_W'(off_user) + RW_I;
      locked = ~lock1[reg_sel];
    end
  end
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DATA_W    = 16,
  parameter int USER_REGS = 16,
  parameter int REG_WORDS = 8,
  localparam int WORDS    = REG_WORDS * (USER_REGS + 1),
  localparam int IDX_W    = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_data,
  input  logic                 we_lock0,
  input  logic                 we_lock1,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [DATA_W-1:0]    rd_word,
  output logic [DATA_W-1:0]    lock0,
  output logic [USER_REGS-1:0] lock1
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (we_data) begin
      mem[wr_idx] <= mem[wr_idx] & wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock0 <= {{(DATA_W-1){1'b1}}, 1'b0};
      lock1 <= '1;
    end else begin
      if (we_lock0) lock0 <= lock0 & wdata;
      if (we_lock1) lock1 <= lock1 & wdata[USER_REGS-1:0];
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
  import otp_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  region_e           tgt_region,
  input  logic              tgt_locked,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              prog_fire,
  output logic              clr_fire,
  output logic              we_data,
  output logic              we_lock0,
  output logic              we_lock1,
  output logic              perr,
  output logic              lerr,
  output logic              stat_mode
);
  logic armed;

  assign prog_fire = wr_fire && armed;
  assign clr_fire  = wr_fire && !armed && (wr_data[7:0] == CMD_CLR_STAT);
  assign we_data   = prog_fire && (tgt_region == RGN_DATA) && !tgt_locked;
  assign we_lock0  = prog_fire && (tgt_region == RGN_LOCK0);
  assign we_lock1  = prog_fire && (tgt_region == RGN_LOCK1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      tgt_addr  <= '0;
      perr      <= 1'b0;
      lerr      <= 1'b0;
      stat_mode <= 1'b0;
    end else if (wr_fire) begin
      if (armed) begin
        armed <= 1'b0;
        if (tgt_region == RGN_NONE) begin
          perr <= 1'b1;
        end else if (tgt_region == RGN_DATA && tgt_locked) begin
          perr <= 1'b1;
          lerr <= 1'b1;
        end
      end else begin
        case (wr_data[7:0])
          CMD_PROGRAM: begin
            armed    <= 1'b1;
            tgt_addr <= wr_addr;
          end
          CMD_READ_STAT: stat_mode <= 1'b1;
          CMD_READ_ARR:  stat_mode <= 1'b0;
          CMD_CLR_STAT: begin
            perr <= 1'b0;
            lerr <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int USER_REGS = 16,
  parameter int REG_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rdata_valid,
  input  logic              rdata_ready,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = REG_WORDS * (USER_REGS + 1);
  localparam int IDX_W = $clog2(WORDS);

  logic                 wr_fire, rd_fire;
  logic [ADDR_W-1:0]    tgt_addr;
  region_e              tgt_region, rd_region;
  logic [IDX_W-1:0]     tgt_idx, rd_idx;
  logic                 tgt_locked, rd_locked;
  logic                 prog_fire, clr_fire;
  logic                 we_data, we_lock0, we_lock1;
  logic                 perr_q, lerr_q, stat_mode;
  logic [DATA_W-1:0]    mem_word, lock0_q;
  logic [USER_REGS-1:0] lock1_q;
  logic [DATA_W-1:0]    status_word, array_word;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid;
  assign rd_ready = !rdata_valid || rdata_ready;
  assign rd_fire  = rd_valid && rd_ready;

  otp_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .tgt_region(tgt_region), .tgt_locked(tgt_locked),
    .tgt_addr(tgt_addr), .prog_fire(prog_fire), .clr_fire(clr_fire),
    .we_data(we_data), .we_lock0(we_lock0), .we_lock1(we_lock1),
    .perr(perr_q), .lerr(lerr_q), .stat_mode(stat_mode)
  );

  otp_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_REGS(USER_REGS),
                 .REG_WORDS(REG_WORDS)) u_map_prog (
    .addr(tgt_addr), .lock0(lock0_q), .lock1(lock1_q),
    .region(tgt_region), .idx(tgt_idx), .locked(tgt_locked)
  );

  otp_addr_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_REGS(USER_REGS),
                 .REG_WORDS(REG_WORDS)) u_map_read (
    .addr(rd_addr), .lock0(lock0_q), .lock1(lock1_q),
    .region(rd_region), .idx(rd_idx), .locked(rd_locked)
  );

  otp_store #(.DATA_W(DATA_W), .USER_REGS(USER_REGS),
              .REG_WORDS(REG_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .we_data(we_data), .we_lock0(we_lock0),
    .we_lock1(we_lock1), .wr_idx(tgt_idx), .wdata(wr_data),
    .rd_idx(rd_idx), .rd_word(mem_word), .lock0(lock0_q), .lock1(lock1_q)
  );

  always_comb begin
    status_word               = '0;
    status_word[ST_READY_BIT] = 1'b1;
    status_word[ST_PERR_BIT]  = perr_q;
    status_word[ST_LERR_BIT]  = lerr_q;
    case (rd_region)
      RGN_LOCK0: array_word = lock0_q;
      RGN_LOCK1: array_word = {{(DATA_W-USER_REGS){1'b1}}, lock1_q};
      RGN_DATA:  array_word = mem_word;
      default:   array_word = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_valid <= 1'b0;
      rdata       <= '0;
    end else if (rd_fire) begin
      rdata_valid <= 1'b1;
      rdata       <= stat_mode ? status_word : array_word;
    end else if (rdata_ready) begin
      rdata_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/otp_prot_ctrl_chk.sv
module otp_prot_ctrl_chk #(
  parameter int DATA_W    = 16,
  parameter int USER_REGS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DATA_W-1:0]    lock0,
  input logic [USER_REGS-1:0] lock1,
  input logic                 perr,
  input logic                 lerr,
  input logic                 prog_fire,
  input logic                 clr_fire,
  input logic                 rdata_valid,
  input logic                 rdata_ready,
  input logic [DATA_W-1:0]    rdata
);
  // R6
  lock0_no_unset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock0 & ~$past(lock0)) == '0));
  // R6
  lock1_no_unset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock1 & ~$past(lock1)) == '0));
  // R7
  factory_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock0[0]);
  // R5
  lerr_with_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lerr |-> perr);
  // R4
  perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> $past(prog_fire));
  // R9
  clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (!perr && !lerr));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_valid && !rdata_ready) |=> (rdata_valid && $stable(rdata)));
endmodule

bind otp_prot_ctrl otp_prot_ctrl_chk #(.DATA_W(DATA_W), .USER_REGS(USER_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock0(lock0_q), .lock1(lock1_q),
  .perr(perr_q), .lerr(lerr_q), .prog_fire(prog_fire), .clr_fire(clr_fire),
  .rdata_valid(rdata_valid), .rdata_ready(rdata_ready), .rdata(rdata)
);

// File: tb/otp_prot_ctrl_bench.sv
module otp_prot_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [8:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [8:0]  rd_addr = '0;
  logic        rdata_valid;
  logic        rdata_ready = 1'b1;
  logic [15:0] rdata;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit hold_rsp = 0;
  bit bp_on = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] ref_mem [136];
  logic [15:0] ref_l0;
  logic [15:0] ref_l1;
  bit          ref_pe, ref_le;

  always #2 clk = ~clk;

  otp_prot_ctrl u_otp_prot_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rdata_valid(rdata_valid),
    .rdata_ready(rdata_ready), .rdata(rdata)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    rdata_ready = hold_rsp ? 1'b0 : (bp_on ? ((cyc % 3) != 0) : 1'b1);
  end

  // monitor: scoreboard pop on each completed response
  always @(negedge clk) begin
    if (rst_n && rdata_valid && rdata_ready) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R10: unexpected response actual=%h expected=none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  function automatic int map_word(input int a);
    if (a >= 'h81 && a <= 'h88) return a - 'h81;
    if (a >= 'h8A && a <= 'h109) return a - 'h8A + 8;
    return -1;
  endfunction

  function automatic bit ref_locked(input int i);
    if (i < 4) return !ref_l0[0];
    if (i < 8) return !ref_l0[1];
    return !ref_l1[(i - 8) / 8];
  endfunction

  function automatic logic [15:0] ref_word(input int a);
    int i;
    if (a == 'h80) return ref_l0;
    if (a == 'h89) return ref_l1;
    i = map_word(a);
    if (i >= 0) return ref_mem[i];
    return 16'hFFFF;
  endfunction

  function automatic logic [15:0] ref_status();
    return 16'h0080 | (16'(ref_pe) << 4) | (16'(ref_le) << 1);
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 9'(a); wr_data = d;
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic do_read(input int a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 9'(a);
    #1;
    while (!rd_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk);
    #1 rd_valid = 1'b0;
  endtask

  // R1 R2 R4 R5 R6: reference update follows the requirement text
  task automatic prog_split(input int a_cmd, input int a_dat, input logic [15:0] d);
    int i;
    wr(a_cmd, 16'h00C0);
    wr(a_dat, d);
    if (a_cmd == 'h80) ref_l0 = ref_l0 & d;
    else if (a_cmd == 'h89) ref_l1 = ref_l1 & d;
    else begin
      i = map_word(a_cmd);
      if (i < 0) ref_pe = 1;
      else if (ref_locked(i)) begin ref_pe = 1; ref_le = 1; end
      else ref_mem[i] = ref_mem[i] & d;
    end
  endtask

  task automatic prog(input int a, input logic [15:0] d);
    prog_split(a, a, d);
  endtask

  task automatic chk_word(input int a, input string t);
    do_read(a, ref_word(a), t);
  endtask

  task automatic chk_status(input string t);
    wr(0, 16'h0070);
    do_read(0, ref_status(), t);
    wr(0, 16'h00FF);
  endtask

  task automatic clr_status();
    wr(0, 16'h0050);
    ref_pe = 0; ref_le = 0;
  endtask

  task automatic drain();
    int k = 0;
    while (exp_q.size() != 0 && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 136; i++) ref_mem[i] = 16'hFFFF;
    ref_l0 = 16'hFFFE; ref_l1 = 16'hFFFF; ref_pe = 0; ref_le = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state with literal values
    do_read('h80, 16'hFFFE, "R7 lock0 reset");
    do_read('h89, 16'hFFFF, "R7 lock1 reset");
    do_read('h85, 16'hFFFF, "R7 data reset");
    do_read('h109, 16'hFFFF, "R7 last word reset");
    wr(0, 16'h0070);
    do_read(0, 16'h0080, "R7 status reset");
    wr(0, 16'h00FF);

    // R11 write channel never stalls
    n_checks++;
    if (wr_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R11: wr_ready actual=%b expected=1", wr_ready);
    end

    // R2 R3 first and last word of the upper half and of every user register
    prog('h85, 16'h1234);
    prog('h88, 16'hABCD);
    for (int r = 0; r < 16; r++) begin
      prog('h8A + 8 * r, 16'(16'hF0F0 ^ r));
      prog('h8A + 8 * r + 7, 16'(16'h0FF0 | (r << 12)));
    end
    chk_word('h85, "R3 upper half first");
    chk_word('h88, "R3 upper half last");
    chk_word('h84, "R3 lower half untouched");
    for (int r = 0; r < 16; r++) begin
      chk_word('h8A + 8 * r, "R3 user first word");
      chk_word('h8A + 8 * r + 7, "R3 user last word");
      chk_word('h8A + 8 * r + 3, "R3 user middle untouched");
    end
    chk_status("R2 no error after valid programs");

    // R2 AND merge, bits never return to one
    bp_on = 1;
    prog('h85, 16'hFF0F);
    do_read('h85, 16'h1204, "R2 and merge");
    prog('h85, 16'hFFFF);
    do_read('h85, 16'h1204, "R2 ones do not restore");
    do_read('h10A, 16'hFFFF, "R3 beyond area reads ones");

    // R1 target is the command-cycle address
    prog_split('h90, 'h91, 16'h00F0);
    chk_word('h90, "R1 command address programmed");
    chk_word('h91, "R1 data address untouched");

    // R4 out of range
    prog('h10, 16'h0000);
    prog('h10A, 16'h0000);
    chk_status("R4 range error status");
    chk_word('h85, "R4 data unchanged");
    clr_status();
    chk_status("R9 status cleared");

    // R5 R8 lower half locked from reset
    prog('h81, 16'h0000);
    chk_word('h81, "R5 lower half unchanged");
    chk_status("R5 lock error status");

    // R9 flags sticky across a valid program
    prog('h86, 16'h7777);
    chk_status("R9 flags sticky");
    clr_status();

    // R9 status mode applies to any address and persists over reads
    wr(0, 16'h0070);
    do_read('h85, 16'h0080, "R9 status at data address");
    do_read('h1FF, 16'h0080, "R9 status persists");
    wr(0, 16'h00FF);
    chk_word('h86, "R9 back to array mode");

    // R6 R8 lock user register 4 via lock word 1 bit 3
    prog('h89, 16'hFFF7);
    do_read('h89, 16'hFFF7, "R6 lock1 programmed");
    prog('hA2, 16'h0000);
    chk_word('hA2, "R8 locked user reg unchanged");
    chk_status("R5 lock error on user reg");
    clr_status();
    prog('hAA, 16'h5A5A);
    chk_word('hAA, "R8 neighbour reg still writable");
    chk_status("R8 neighbour no error");

    // R6 R8 lock upper half via lock word 0 bit 1
    prog('h80, 16'hFFFD);
    do_read('h80, 16'hFFFC, "R6 lock0 programmed");
    prog('h87, 16'h0000);
    chk_word('h87, "R8 upper half now locked");
    chk_status("R8 lock error upper half");
    clr_status();

    // R6 lock bits cannot be set back to one
    prog('h89, 16'hFFFF);
    do_read('h89, 16'hFFF7, "R6 lock1 stays cleared");
    prog('h80, 16'hFFFF);
    do_read('h80, 16'hFFFC, "R6 lock0 stays cleared");
    chk_status("R6 lock programs raise no error");

    // R11 unknown code ignored
    wr('h8B, 16'h0012);
    wr('h8B, 16'h0000);
    chk_word('h8B, "R11 unknown code no program");
    chk_status("R11 unknown code no status");

    // R10 response held under back-pressure
    bp_on = 0;
    drain();
    hold_rsp = 1;
    @(negedge clk);
    do_read('h85, 16'h1204, "R10 stalled response");
    repeat (3) @(negedge clk);
    n_checks++;
    if (rdata_valid !== 1'b1 || rd_ready !== 1'b0 || rdata !== 16'h1204) begin
      n_fail++;
      $display("FAIL R10: valid/ready/data actual=%b/%b/%h expected=1/0/1204",
               rdata_valid, rd_ready, rdata);
    end
    hold_rsp = 0;
    drain();

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R10: pending responses actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule